// File: doc/BRIEF.md
# Boundary-Scan Cell Chain for General-Purpose I/O Pins

This block is a parameterised chain of boundary-scan cells placed between a core's port logic and its pads. Every pin contributes four scan cells: one for the pad input value, one for output data, one for output enable and one for pull-up disable. A configurable number of generic auxiliary cells, for example at the edge between analog and digital logic, sits at the TDI end of the chain. An external test-access controller supplies the capture, shift and update strobes, a chain-select flag and an external-test mode flag. This block does not decode instructions and does not run the TAP state machine.

On every test-clock edge the chain performs exactly one operation. The operations are named states of a small decoder. `OP_HOLD` keeps the cells. `OP_CAPTURE` samples the core-driven controls and the pad inputs. `OP_SHIFT` moves the chain one place toward TDO. The decoder chooses `OP_CAPTURE` when the chain is selected and the capture strobe is high. Otherwise it chooses `OP_SHIFT` when the chain is selected and the shift strobe is high. In every other case it chooses `OP_HOLD`. The update strobe, when the chain is selected, copies the shift stages into a separate bank of update latches.

The pads run in one of two modes. In functional mode the core drives the pads and the latches only hold values, which allows a preload. In test mode the latches drive the pads. The block enters test mode when the external-test flag is high and the test reset is released. It returns to functional mode when the flag drops or the test reset is asserted.

Top module: `bscan_port_chain`

## Requirements
- R1: An active-low test reset clears every shift stage and every update latch. TDO reads 0 after reset. If test mode is entered straight after reset, the pads and auxiliary outputs show 0.
- R2: While the test reset is low, the pad enable, data and pull-up-disable outputs and the auxiliary outputs follow the core values, even if the external-test flag is high.
- R3: Capture loads the cells as follows. Cell 4p takes pad input p. Cell 4p+1 takes core output data p. Cell 4p+2 takes core output enable p. Cell 4p+3 takes core pull-up disable p. Cell 4·PINS+k takes auxiliary input k. Cell 0 is the one nearest TDO.
- R4: Each shift edge moves every cell one position toward TDO. TDI enters the highest cell, and TDO always presents cell 0.
- R5: Update copies the shift stages into the update latches. While the external-test flag is low, the pads keep following the core after an update (preload).
- R6: With the external-test flag high, the pads are driven from the latches. For pin p, output data comes from latched cell 4p+1, output enable from cell 4p+2 and pull-up disable from cell 4p+3. Auxiliary output k comes from latched cell 4·PINS+k.
- R7: Capture and shift never change the pad or auxiliary outputs. Only an update, a mode change or a core change does.
- R8: When the chain-select flag is low, all capture, shift and update strobes are ignored.
- R9: The core's input-data outputs always equal the pad inputs, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all cells act on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| chain_sel | input | 1 | This chain is the selected data register |
| ext_test | input | 1 | External-test mode: latches drive the pads |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| core_pud | input | PINS | Core pull-up disable per pin |
| core_oe | input | PINS | Core output enable per pin |
| core_do | input | PINS | Core output data per pin |
| core_di | output | PINS | Pad input value returned to the core |
| pad_di | input | PINS | Value seen on each pad |
| pad_pud | output | PINS | Pull-up disable to the pads |
| pad_oe | output | PINS | Output enable to the pads |
| pad_do | output | PINS | Output data to the pads |
| aux_core | input | AUX | Functional drive for auxiliary cells |
| aux_in | input | AUX | Values captured by auxiliary cells |
| aux_out | output | AUX | Auxiliary outputs |

## Verification
The bench builds the block with three pins and two auxiliary cells, which gives a 14-cell chain. At this size every cell type and both auxiliary cells are walked bit by bit through TDO, and each pin's enable, data and pull-up-disable fields are compared against distinct latched patterns. The small pin count lets every pin take a different core and pad value, so an error in cell ordering or field swapping shows up as a miscompare. Preload, test-mode switching, unselected strobes and a reset during test mode are all exercised on this single configuration.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int CELLS_PER_PIN = 4;
    localparam int CELL_DI  = 0;
    localparam int CELL_DO  = 1;
    localparam int CELL_OE  = 2;
    localparam int CELL_PUD = 3;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } scan_op_e;

    function automatic int cell_idx(input int pin, input int field);
        return pin * CELLS_PER_PIN + field;
    endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage
    import bscan_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           sel,
    input  logic           capture_en,
    input  logic           shift_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] stages,
    output logic           tdo
);

    scan_op_e op;

    always_comb begin
        if (!sel)            op = OP_HOLD;
        else if (capture_en) op = OP_CAPTURE;
        else if (shift_en)   op = OP_SHIFT;
        else                 op = OP_HOLD;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stages <= '0;
        end else begin
            unique case (op)
                OP_CAPTURE: stages <= cap_vec;
                OP_SHIFT:   stages <= {tdi, stages[LEN-1:1]};
                OP_HOLD:    stages <= stages;
                default:    stages <= stages;
            endcase
        end
    end

    assign tdo = stages[0];

    p_shift_moves_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && shift_en && !capture_en) |=>
            (stages[LEN-2:0] == $past(stages[LEN-1:1])) && (stages[LEN-1] == $past(tdi)));

    p_capture_load_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_en) |=> (stages == $past(cap_vec)));

    p_unselected_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> $stable(stages));

endmodule

// File: rtl/bscan_update_latch.sv
module bscan_update_latch #(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           load,
    input  logic [LEN-1:0] d,
    output logic [LEN-1:0] q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) q <= '0;
        else if (load) q <= d;
    end

    p_latch_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
        load |=> (q == $past(d)));

    p_latch_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter int PINS = 4,
    parameter int AUX  = 1,
    localparam int LEN = PINS * CELLS_PER_PIN + AUX
) (
    input  logic            test_mode,
    input  logic [LEN-1:0]  latched,
    input  logic [PINS-1:0] core_pud,
    input  logic [PINS-1:0] core_oe,
    input  logic [PINS-1:0] core_do,
    input  logic [AUX-1:0]  aux_core,
    output logic [PINS-1:0] pad_pud,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do,
    output logic [AUX-1:0]  aux_out
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pad_do[p]  = test_mode ? latched[cell_idx(p, CELL_DO)]  : core_do[p];
        assign pad_oe[p]  = test_mode ? latched[cell_idx(p, CELL_OE)]  : core_oe[p];
        assign pad_pud[p] = test_mode ? latched[cell_idx(p, CELL_PUD)] : core_pud[p];
    end

    for (genvar k = 0; k < AUX; k++) begin : g_aux
        assign aux_out[k] = test_mode ? latched[PINS*CELLS_PER_PIN + k] : aux_core[k];
    end

endmodule

// File: rtl/bscan_port_chain.sv
module bscan_port_chain
    import bscan_pkg::*;
#(
    parameter int PINS = 4,
    parameter int AUX  = 1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            chain_sel,
    input  logic            ext_test,
    input  logic            capture_en,
    input  logic            shift_en,
    input  logic            update_en,
    input  logic            tdi,
    output logic            tdo,
    input  logic [PINS-1:0] core_pud,
    input  logic [PINS-1:0] core_oe,
    input  logic [PINS-1:0] core_do,
    output logic [PINS-1:0] core_di,
    input  logic [PINS-1:0] pad_di,
    output logic [PINS-1:0] pad_pud,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do,
    input  logic [AUX-1:0]  aux_core,
    input  logic [AUX-1:0]  aux_in,
    output logic [AUX-1:0]  aux_out
);

    localparam int PIN_CELLS = PINS * CELLS_PER_PIN;
    localparam int LEN       = PIN_CELLS + AUX;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] stages;
    logic [LEN-1:0] latched;
    logic           test_mode;

    for (genvar p = 0; p < PINS; p++) begin : g_cap
        assign cap_vec[cell_idx(p, CELL_DI)]  = pad_di[p];
        assign cap_vec[cell_idx(p, CELL_DO)]  = core_do[p];
        assign cap_vec[cell_idx(p, CELL_OE)]  = core_oe[p];
        assign cap_vec[cell_idx(p, CELL_PUD)] = core_pud[p];
    end
    assign cap_vec[LEN-1:PIN_CELLS] = aux_in;

    assign test_mode = ext_test && trst_n;
    assign core_di   = pad_di;

    bscan_shift_stage #(.LEN(LEN)) u_shift (
        .tck        (tck),
        .trst_n     (trst_n),
        .sel        (chain_sel),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .stages     (stages),
        .tdo        (tdo)
    );

    bscan_update_latch #(.LEN(LEN)) u_latch (
        .tck    (tck),
        .trst_n (trst_n),
        .load   (chain_sel && update_en),
        .d      (stages),
        .q      (latched)
    );

    bscan_pad_mux #(.PINS(PINS), .AUX(AUX)) u_mux (
        .test_mode (test_mode),
        .latched   (latched),
        .core_pud  (core_pud),
        .core_oe   (core_oe),
        .core_do   (core_do),
        .aux_core  (aux_core),
        .pad_pud   (pad_pud),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do),
        .aux_out   (aux_out)
    );

    p_pads_quiet_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (!update_en && $stable(ext_test) && $stable(core_oe) && $stable(core_do)
         && $stable(core_pud)) |=> ($stable(pad_oe) && $stable(pad_do) && $stable(pad_pud)));

endmodule

// File: tb/bscan_port_chain_test.sv
module bscan_port_chain_test;

    localparam int NP = 3;
    localparam int NA = 2;
    localparam int L  = NP * 4 + NA;
    localparam time CLK_PERIOD = 10ns;

    typedef enum {K_TDO, K_OE, K_DO, K_PUD, K_AUX, K_CDI} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic tck = 0, trst_n = 0, chain_sel = 0, ext_test = 0;
    logic capture_en = 0, shift_en = 0, update_en = 0, tdi = 0;
    logic tdo;
    logic [NP-1:0] core_pud = '0, core_oe = '0, core_do = '0, core_di, pad_di = '0;
    logic [NP-1:0] pad_pud, pad_oe, pad_do;
    logic [NA-1:0] aux_core = '0, aux_in = '0, aux_out;

    item_t q[$];
    event chk_ev;
    int applied = 0, failed = 0;
    bit done = 0;
    logic [L-1:0] model;

    always #(CLK_PERIOD/2) tck = ~tck;

    bscan_port_chain #(.PINS(NP), .AUX(NA)) uut (
        .tck(tck), .trst_n(trst_n), .chain_sel(chain_sel), .ext_test(ext_test),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdi(tdi), .tdo(tdo), .core_pud(core_pud), .core_oe(core_oe),
        .core_do(core_do), .core_di(core_di), .pad_di(pad_di),
        .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_do(pad_do),
        .aux_core(aux_core), .aux_in(aux_in), .aux_out(aux_out)
    );

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_TDO:   act = 32'(tdo);
                    K_OE:    act = 32'(pad_oe);
                    K_DO:    act = 32'(pad_do);
                    K_PUD:   act = 32'(pad_pud);
                    K_AUX:   act = 32'(aux_out);
                    default: act = 32'(core_di);
                endcase
                applied++;
                if (act !== it.exp) begin
                    failed++;
                    $display("FAIL %s kind=%s actual=%0h expected=%0h",
                             it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic push(kind_e k, logic [31:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic flush();
        #1;
        -> chk_ev;
        wait (q.size() == 0);
    endtask

    task automatic tick();
        @(posedge tck);
        @(negedge tck);
    endtask

    function automatic logic [NP-1:0] field(logic [L-1:0] v, int f);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = v[p*4 + f];
        return r;
    endfunction

    function automatic logic [L-1:0] cap_model();
        logic [L-1:0] m;
        for (int p = 0; p < NP; p++) begin
            m[p*4+0] = pad_di[p];
            m[p*4+1] = core_do[p];
            m[p*4+2] = core_oe[p];
            m[p*4+3] = core_pud[p];
        end
        for (int k = 0; k < NA; k++) m[NP*4+k] = aux_in[k];
        return m;
    endfunction

    task automatic expect_core(string r);
        push(K_OE,  32'(core_oe),  r);
        push(K_DO,  32'(core_do),  r);
        push(K_PUD, 32'(core_pud), r);
        push(K_AUX, 32'(aux_core), r);
        flush();
    endtask

    task automatic expect_latched(logic [L-1:0] v, string r);
        push(K_DO,  32'(field(v, 1)), r);
        push(K_OE,  32'(field(v, 2)), r);
        push(K_PUD, 32'(field(v, 3)), r);
        push(K_AUX, 32'(v[L-1:NP*4]), r);
        flush();
    endtask

    // shift the whole chain, checking TDO each step; optionally check pads stay put
    task automatic shift_all(logic [L-1:0] pat, bit chk_latched, logic [L-1:0] held, string r);
        for (int k = 0; k < L; k++) begin
            shift_en = 1; tdi = pat[k];
            tick();
            model = {pat[k], model[L-1:1]};
            push(K_TDO, 32'(model[0]), r);
            flush();
            if (chk_latched) expect_latched(held, "R7");
            else expect_core("R7");
        end
        shift_en = 0;
    endtask

    initial begin
        logic [L-1:0] pat1, pat2;
        pat1 = 14'b10_1101_0011_1001;
        pat2 = 14'b01_0110_1100_0110;

        // reset, with the external-test flag high
        ext_test = 1;
        core_oe = 3'b101; core_do = 3'b011; core_pud = 3'b110;
        pad_di = 3'b010; aux_core = 2'b10; aux_in = 2'b01;
        #(CLK_PERIOD*2);
        @(negedge tck);
        push(K_TDO, 0, "R1"); flush();
        expect_core("R2");
        push(K_CDI, 32'(pad_di), "R9"); flush();

        trst_n = 1; ext_test = 0;
        @(negedge tck);
        expect_core("R2");

        // capture, then shift out with pattern 1 (functional mode)
        chain_sel = 1; capture_en = 1;
        tick();
        capture_en = 0;
        model = cap_model();
        push(K_TDO, 32'(model[0]), "R3"); flush();
        shift_all(pat1, 0, '0, "R3");
        push(K_TDO, 32'(pat1[0]), "R4"); flush();

        // update while functional: preload only
        update_en = 1; tick(); update_en = 0;
        expect_core("R5");

        // enter test mode
        ext_test = 1; #1;
        expect_latched(pat1, "R6");

        // R9 in test mode
        pad_di = 3'b101; #1;
        push(K_CDI, 32'(pad_di), "R9"); flush();

        // capture a new snapshot, shift in pattern 2, pads hold pattern 1
        core_oe = 3'b010; core_do = 3'b100; core_pud = 3'b001; aux_in = 2'b10;
        capture_en = 1; tick(); capture_en = 0;
        model = cap_model();
        push(K_TDO, 32'(model[0]), "R3"); flush();
        expect_latched(pat1, "R7");
        shift_all(pat2, 1, pat1, "R4");
        update_en = 1; tick(); update_en = 0;
        expect_latched(pat2, "R6");

        // unselected strobes ignored
        chain_sel = 0;
        capture_en = 1; tick(); capture_en = 0;
        push(K_TDO, 32'(model[0]), "R8"); flush();
        shift_en = 1; tdi = 1;
        for (int k = 0; k < 3; k++) tick();
        shift_en = 0;
        push(K_TDO, 32'(model[0]), "R8"); flush();
        update_en = 1; tick(); update_en = 0;
        expect_latched(pat2, "R8");
        chain_sel = 1;
        shift_all(pat1, 1, pat2, "R8");

        // reset in test mode: functional while low, cleared latches after
        trst_n = 0; #1;
        expect_core("R2");
        push(K_TDO, 0, "R1"); flush();
        @(negedge tck);
        trst_n = 1; #1;
        expect_latched('0, "R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            failed++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
            $finish;
        end
    end

endmodule